// File: doc/BRIEF.md
# Window Framebuffer Fetch Address Generator

This block produces the read requests that pull one overlay window out of a larger framebuffer in memory. The window is a rectangular crop: each display line of the window is a contiguous run of bytes, and consecutive lines are separated by a gap equal to the part of the framebuffer row that lies outside the window. Software works out the first fetch address (buffer base plus the horizontal crop offset in bytes plus the vertical crop offset times the row pitch), the exclusive end address (first address plus framebuffer width times window height times bytes per pixel), the per-line payload in bytes and the per-line gap in bytes. The block walks these lines in bursts and raises a one-cycle pulse when the frame has been fully requested.

The burst length is picked from the pixel format code and the framebuffer width: palette formats use short bursts, 16- and 32-bit formats use long ones, and narrow framebuffers always use the shortest burst so that small buffers such as cursors fetch steadily. The last burst of each line is cut down so it never runs past the line payload.

Requests leave on a valid/ready stream. Once `req_valid` is high it stays high, and `req_addr` and `req_len` stay unchanged, until the cycle in which `req_ready` is also high; that cycle transfers the request. The consumer may hold `req_ready` low for any number of cycles. `frame_start` is a plain pulse and is only honoured while no frame is in progress.

Top module: `win_fetch_addr`

## Requirements
- R1: After reset, `req_valid` and `frame_done` are low and stay low until a frame is started.
- R2: The first request of a frame carries the sampled start address; each further request in the same line is at the previous address plus the previous length times 4 bytes.
- R3: Format code 0 (8-bit palette) selects 8-word bursts; codes 1 and 2 (16-bit) and codes 3 and 4 (32-bit) select 16-word bursts.
- R4: Any other format code (5 to 7) is handled as unpacked 32-bit data and selects 16-word bursts.
- R5: When the framebuffer width is below 128 pixels the burst is 4 words for every format; at exactly 128 pixels the format rule applies.
- R6: Every request has a length of at least 1 word and at most the selected burst; the last request of a line covers exactly the remaining payload words (payload bytes are a multiple of 4).
- R7: After the last request of a line, the next line begins at the previous line's first address plus the payload bytes plus the gap bytes.
- R8: When the next line address is at or above the end address, no further requests are made and `frame_done` is high for exactly one cycle, the cycle after the final transfer; a frame whose start address is not below its end address, or whose payload is zero, makes no request and pulses `frame_done` in the cycle after `frame_start`.
- R9: While `req_valid` is high and `req_ready` is low, the request is held: valid stays high and address and length do not change.
- R10: Configuration is sampled only when `frame_start` is accepted in idle; `frame_start` and configuration changes while a frame is in progress have no effect on the requests of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Pulse that starts a frame when idle |
| cfg_start_addr | input | ADDR_W | First fetch address in bytes |
| cfg_end_addr | input | ADDR_W | Exclusive end address in bytes |
| cfg_line_bytes | input | LINE_W | Payload bytes per line, multiple of 4 |
| cfg_skip_bytes | input | LINE_W | Gap bytes between lines |
| cfg_fmt | input | 3 | Pixel format code |
| cfg_fb_width | input | WID_W | Framebuffer width in pixels |
| req_valid | output | 1 | Request stream valid |
| req_ready | input | 1 | Request stream ready |
| req_addr | output | ADDR_W | Byte address of the burst |
| req_len | output | LEN_W | Burst length in 4-byte words |
| frame_done | output | 1 | One-cycle pulse after the final request |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 16-bit line fields, a 128-pixel narrow-width threshold and bursts of 4, 8 and 16 words. With these, framebuffer widths of 64, 128 and 200 pixels straddle the threshold, and payloads of 25, 10 and 36 words leave tails of 1, 2 and 4 words, so both the burst selection and the shortened last burst are reached. Random and long stretches of low `req_ready`, a zero-payload frame, an empty address range and a restart attempt with altered configuration mid-frame cover the hold, termination and sampling rules.

// File: rtl/wfa_pkg.sv
package wfa_pkg;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned FMT_W = 3;

  localparam logic [FMT_W-1:0] FMT_PAL8    = 3'd0;
  localparam logic [FMT_W-1:0] FMT_RGB1555 = 3'd1;
  localparam logic [FMT_W-1:0] FMT_RGB565  = 3'd2;
  localparam logic [FMT_W-1:0] FMT_XRGB32  = 3'd3;
  localparam logic [FMT_W-1:0] FMT_ARGB32  = 3'd4;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } wfa_state_e;
endpackage

// File: rtl/wfa_burst_sel.sv
module wfa_burst_sel
  import wfa_pkg::*;
#(
  parameter int unsigned WID_W        = 12,
  parameter int unsigned LEN_W        = 5,
  parameter int unsigned MIN_WIDTH    = 128,
  parameter int unsigned BURST_NARROW = 4,
  parameter int unsigned BURST_PAL    = 8,
  parameter int unsigned BURST_WIDE   = 16
) (
  input  logic [FMT_W-1:0] fmt,
  input  logic [WID_W-1:0] fb_width,
  output logic [LEN_W-1:0] burst_words
);
  logic [LEN_W-1:0] by_fmt;

  always_comb begin
    unique case (fmt)
      FMT_PAL8:                              by_fmt = LEN_W'(BURST_PAL);
      FMT_RGB1555, FMT_RGB565:               by_fmt = LEN_W'(BURST_WIDE);
      FMT_XRGB32, FMT_ARGB32:                by_fmt = LEN_W'(BURST_WIDE);
      default:                               by_fmt = LEN_W'(BURST_WIDE);
    endcase
  end

  assign burst_words = (32'(fb_width) < MIN_WIDTH) ? LEN_W'(BURST_NARROW) : by_fmt;
endmodule

// File: rtl/wfa_walker.sv
module wfa_walker
  import wfa_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LINE_W = 16,
  parameter int unsigned LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [ADDR_W-1:0] cfg_start_addr,
  input  logic [ADDR_W-1:0] cfg_end_addr,
  input  logic [LINE_W-1:0] cfg_line_bytes,
  input  logic [LINE_W-1:0] cfg_skip_bytes,
  input  logic [LEN_W-1:0]  burst_in,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W-1:0]  req_len,
  output logic              frame_done,
  output logic [LEN_W-1:0]  burst_held
);
  localparam int unsigned RW = LINE_W - 2;

  wfa_state_e        state_q;
  logic [ADDR_W-1:0] base_q, cur_q, end_q, step_q;
  logic [RW-1:0]     lwords_q, rem_q;
  logic [LEN_W-1:0]  burst_q;
  logic              done_q;

  logic [RW-1:0]     start_words;
  logic              start_empty, accept, xfer, more_in_line, frame_over;
  logic [LEN_W-1:0]  len_now;
  logic [ADDR_W-1:0] next_line;
  logic              unused_lsb;

  assign start_words  = cfg_line_bytes[LINE_W-1:2];
  assign unused_lsb   = ^cfg_line_bytes[1:0];
  assign start_empty  = (cfg_start_addr >= cfg_end_addr) || (start_words == '0);
  assign accept       = frame_start && (state_q == ST_IDLE);
  assign len_now      = (rem_q < RW'(burst_q)) ? LEN_W'(rem_q) : burst_q;
  assign xfer         = (state_q == ST_RUN) && req_ready;
  assign more_in_line = rem_q > RW'(len_now);
  assign next_line    = base_q + step_q;
  assign frame_over   = next_line >= end_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      base_q   <= '0;
      cur_q    <= '0;
      end_q    <= '0;
      step_q   <= '0;
      lwords_q <= '0;
      rem_q    <= '0;
      burst_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        base_q   <= cfg_start_addr;
        cur_q    <= cfg_start_addr;
        end_q    <= cfg_end_addr;
        step_q   <= ADDR_W'(cfg_line_bytes) + ADDR_W'(cfg_skip_bytes);
        lwords_q <= start_words;
        rem_q    <= start_words;
        burst_q  <= burst_in;
        if (start_empty) done_q  <= 1'b1;
        else             state_q <= ST_RUN;
      end else if (xfer) begin
        if (more_in_line) begin
          cur_q <= cur_q + (ADDR_W'(len_now) << 2);
          rem_q <= rem_q - RW'(len_now);
        end else if (frame_over) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end else begin
          base_q <= next_line;
          cur_q  <= next_line;
          rem_q  <= lwords_q;
        end
      end
    end
  end

  assign req_valid  = (state_q == ST_RUN);
  assign req_addr   = cur_q;
  assign req_len    = len_now;
  assign frame_done = done_q;
  assign burst_held = burst_q;

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_len))
    else $error("request changed under back-pressure");

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && more_in_line |=> req_addr == $past(req_addr) + (ADDR_W'($past(req_len)) << 2))
    else $error("in-line address step wrong");

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done)
    else $error("frame_done longer than one cycle");

  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !req_valid)
    else $error("request alongside frame_done");
endmodule

// File: rtl/win_fetch_addr.sv
module win_fetch_addr
  import wfa_pkg::*;
#(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned LINE_W       = 16,
  parameter int unsigned WID_W        = 12,
  parameter int unsigned MIN_WIDTH    = 128,
  parameter int unsigned BURST_NARROW = 4,
  parameter int unsigned BURST_PAL    = 8,
  parameter int unsigned BURST_WIDE   = 16,
  localparam int unsigned BURST_MAX   = (BURST_WIDE > BURST_PAL) ?
                                        ((BURST_WIDE > BURST_NARROW) ? BURST_WIDE : BURST_NARROW) :
                                        ((BURST_PAL > BURST_NARROW) ? BURST_PAL : BURST_NARROW),
  localparam int unsigned LEN_W       = $clog2(BURST_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [ADDR_W-1:0] cfg_start_addr,
  input  logic [ADDR_W-1:0] cfg_end_addr,
  input  logic [LINE_W-1:0] cfg_line_bytes,
  input  logic [LINE_W-1:0] cfg_skip_bytes,
  input  logic [FMT_W-1:0]  cfg_fmt,
  input  logic [WID_W-1:0]  cfg_fb_width,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W-1:0]  req_len,
  output logic              frame_done
);
  logic [LEN_W-1:0] burst_sel_w;
  logic [LEN_W-1:0] burst_held;

  wfa_burst_sel #(
    .WID_W(WID_W), .LEN_W(LEN_W), .MIN_WIDTH(MIN_WIDTH),
    .BURST_NARROW(BURST_NARROW), .BURST_PAL(BURST_PAL), .BURST_WIDE(BURST_WIDE)
  ) u_sel (
    .fmt(cfg_fmt), .fb_width(cfg_fb_width), .burst_words(burst_sel_w)
  );

  wfa_walker #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .LEN_W(LEN_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .cfg_start_addr(cfg_start_addr), .cfg_end_addr(cfg_end_addr),
    .cfg_line_bytes(cfg_line_bytes), .cfg_skip_bytes(cfg_skip_bytes),
    .burst_in(burst_sel_w),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len),
    .frame_done(frame_done), .burst_held(burst_held)
  );

  assert_len_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_len != '0) && (req_len <= burst_held))
    else $error("request length out of range");
endmodule

// File: tb/sim_win_fetch_addr.sv
module sim_win_fetch_addr;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic [31:0] cfg_start_addr = '0, cfg_end_addr = '0;
  logic [15:0] cfg_line_bytes = '0, cfg_skip_bytes = '0;
  logic [2:0]  cfg_fmt = '0;
  logic [11:0] cfg_fb_width = '0;
  logic        req_valid, req_ready;
  logic [31:0] req_addr;
  logic [4:0]  req_len;
  logic        frame_done;

  win_fetch_addr u0 (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .cfg_start_addr(cfg_start_addr), .cfg_end_addr(cfg_end_addr),
    .cfg_line_bytes(cfg_line_bytes), .cfg_skip_bytes(cfg_skip_bytes),
    .cfg_fmt(cfg_fmt), .cfg_fb_width(cfg_fb_width),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .frame_done(frame_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_fail = 0, cyc = 0;
  string tag = "R1";
  int rdy_mode = 0;
  bit rdy_drv = 1'b1;
  assign req_ready = rdy_drv;

  int unsigned qa[$];
  int unsigned ql[$];
  bit m_busy = 1'b0, exp_done = 1'b0;

  task automatic chk(input bit ok, input string t, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  function automatic int exp_burst(input int fmt, input int w);
    if (w < 128) return 4;
    if (fmt == 0) return 8;
    return 16;
  endfunction

  task automatic build_frame();
    int unsigned s = cfg_start_addr, e = cfg_end_addr;
    int lw = int'(cfg_line_bytes) / 4;
    int b = exp_burst(int'(cfg_fmt), int'(cfg_fb_width));
    qa.delete(); ql.delete();
    if (s >= e || lw == 0) return;
    for (int unsigned base = s; base < e; base += int'(cfg_line_bytes) + int'(cfg_skip_bytes)) begin
      for (int w = 0; w < lw; w += b) begin
        qa.push_back(base + 4 * w);
        ql.push_back((lw - w < b) ? lw - w : b);
      end
    end
  endtask

  // reference model, advanced on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; exp_done = 0; qa.delete(); ql.delete();
    end else begin
      bit acc;
      acc = frame_start && !m_busy;
      exp_done = 0;
      if (qa.size() > 0 && rdy_drv) begin
        void'(qa.pop_front()); void'(ql.pop_front());
        if (qa.size() == 0) begin m_busy = 0; exp_done = 1; end
      end
      if (acc) begin
        build_frame();
        if (qa.size() == 0) exp_done = 1;
        else m_busy = 1;
      end
    end
  end

  // ready driver and per-cycle comparison on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(req_valid == (qa.size() > 0), tag, "req_valid", req_valid, qa.size() > 0);
      if (qa.size() > 0) begin
        chk(req_addr == qa[0], tag, "req_addr", req_addr, qa[0]);
        chk(req_len == ql[0], tag, "req_len", req_len, ql[0]);
      end
      chk(frame_done == exp_done, tag, "frame_done", frame_done, exp_done);
    end
    case (rdy_mode)
      0: rdy_drv = 1'b1;
      1: rdy_drv = ($urandom % 4) != 0;
      default: rdy_drv = 1'b0;
    endcase
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  task automatic pulse_start();
    @(negedge clk) frame_start = 1'b1;
    @(negedge clk) frame_start = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (m_busy || exp_done);
    repeat (2) @(negedge clk);
  endtask

  task automatic setup(input int unsigned base, input int fbw, input int bpp,
                       input int x, input int y, input int ww, input int wh, input int fmt);
    cfg_start_addr = base + x * bpp + y * fbw * bpp;
    cfg_end_addr   = cfg_start_addr + fbw * wh * bpp;
    cfg_line_bytes = 16'(ww * bpp);
    cfg_skip_bytes = 16'((fbw - ww) * bpp);
    cfg_fmt        = 3'(fmt);
    cfg_fb_width   = 12'(fbw);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(req_valid == 0, "R1", "req_valid in reset", req_valid, 0);
    chk(frame_done == 0, "R1", "frame_done in reset", frame_done, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 R7 R3: 32-bit format, wide framebuffer, tail of 8 words
    tag = "R2_R7_R3"; setup(32'h1000, 200, 4, 5, 2, 40, 3, 3);
    pulse_start(); wait_idle();

    // R3 R6: palette, 25-word lines give a 1-word tail
    tag = "R3_R6"; setup(32'h8000, 256, 1, 3, 1, 100, 2, 0);
    pulse_start(); wait_idle();

    // R5: narrow framebuffer forces 4-word bursts
    tag = "R5"; setup(32'h20000, 64, 2, 2, 0, 20, 2, 2);
    pulse_start(); wait_idle();

    // R5 boundary: width 128 is not narrow
    tag = "R5_edge"; setup(32'h30000, 128, 2, 0, 4, 24, 2, 1);
    pulse_start(); wait_idle();

    // R4: unknown format, random back-pressure
    tag = "R4_R9"; rdy_mode = 1; setup(32'h40000, 160, 4, 1, 1, 36, 2, 6);
    pulse_start(); wait_idle();

    // R9: long stall in the middle of a frame
    tag = "R9"; rdy_mode = 0; setup(32'h50000, 200, 4, 0, 0, 40, 2, 4);
    pulse_start(); repeat (2) @(negedge clk);
    rdy_mode = 2; repeat (8) @(negedge clk);
    rdy_mode = 1; wait_idle(); rdy_mode = 0;

    // R8: empty range and zero payload
    tag = "R8_empty"; cfg_start_addr = 32'h6000; cfg_end_addr = 32'h6000;
    cfg_line_bytes = 16; pulse_start(); wait_idle();
    tag = "R8_zero"; cfg_end_addr = 32'h6040; cfg_line_bytes = 0;
    pulse_start(); wait_idle();

    // R10: restart attempt with new settings mid-frame is ignored
    tag = "R10"; rdy_mode = 1; setup(32'h70000, 200, 4, 0, 0, 40, 3, 3);
    pulse_start(); repeat (3) @(negedge clk);
    setup(32'h90000, 64, 1, 0, 0, 8, 1, 0);
    pulse_start(); wait_idle(); rdy_mode = 0;

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule